// File: doc/BRIEF.md
# SPI FIFO DMA Request Generator

This block sits between the data FIFOs of an SPI controller and a DMA engine. It watches the fill level of the transmit FIFO and the receive FIFO. From those levels it raises a request line whenever the DMA engine should refill the transmit side or drain the receive side. Each direction has its own enable bit, and a global controller enable overrides both.

Each direction drives a single-word request line and a burst request line, so the DMA engine knows how many words it may move.

- The transmit side compares its level against a programmable watermark, normally half the FIFO depth minus one. It asks for a burst of a quarter of the FIFO depth when that much space is free, and for a single word otherwise.
- The receive side holds a programmable burst size minus one. The size is rounded down to the nearest legal burst of 1, 2, 4 or 8 words. It asks for a drain once that many words are waiting.

All request lines are registered. An acknowledge from the DMA engine drops the matching direction's request long enough for the FIFO level to settle before it is evaluated again.

Top module: `spi_dma_req_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it, all four request outputs are low.
- R2: `dma_ctl` bit 0 enables receive requests and bit 1 enables transmit requests. Whenever a bit was clear at a clock edge, that direction's two request lines are low after the edge.
- R3: When `ctrl_en` was low at a clock edge, all four request lines are low after that edge.
- R4: A transmit request is raised one clock after all of these hold: the transmit enable is set, `tx_level` is at or below `tx_mark`, and `tx_level` is below the FIFO depth. No transmit request is raised when the FIFO is full.
- R5: For a transmit request, the burst line is used when the free space (depth minus `tx_level`) is at least a quarter of the depth. Otherwise the single line is used. The two transmit lines are never high together.
- R6: The effective receive burst is the largest of 1, 2, 4 or 8 that does not exceed `rx_mark`+1. So `rx_mark` values 0..7 give 1, 2, 2, 4, 4, 4, 4, 8.
- R7: A receive request is raised one clock after the receive enable is set and `rx_level` is at least the effective burst. It uses the burst line when the effective burst exceeds 1, and the single line when it equals 1. The two receive lines are never high together.
- R8: When a direction's acknowledge is sampled high at a clock edge, that direction's request lines are low after that edge and after the next one. They are evaluated again from the inputs on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; low forces all requests off |
| dma_ctl | input | 2 | Bit 0 receive DMA enable, bit 1 transmit DMA enable |
| tx_level | input | LVL_W | Words held in the transmit FIFO |
| rx_level | input | LVL_W | Words held in the receive FIFO |
| tx_mark | input | LVL_W | Transmit watermark |
| rx_mark | input | 3 | Receive burst size minus one |
| tx_ack | input | 1 | DMA acknowledge for the transmit side |
| rx_ack | input | 1 | DMA acknowledge for the receive side |
| tx_single_req | output | 1 | Transmit single-word request |
| tx_burst_req | output | 1 | Transmit burst request |
| rx_single_req | output | 1 | Receive single-word request |
| rx_burst_req | output | 1 | Receive burst request |

## Verification
Directed cases place the transmit level exactly at the watermark and one above it. This separates `<=` from `<`. They also fill the FIFO completely, to show the full-FIFO block, and push the free space just below a quarter depth, to split burst from single. On the receive side, every `rx_mark` value is walked with levels one below and exactly at the effective burst. This exposes a wrong rounding of illegal burst sizes. An acknowledge sequence counts the exact number of quiet cycles. Random levels, marks, enables and acknowledges then mix all conditions against a bench model.

// File: rtl/spi_dreq_pkg.sv
package spi_dreq_pkg;

  localparam int unsigned RX_MARK_W = 3;
  localparam int unsigned MAX_BURST = 8;

  // Largest power of two not above mark+1, capped at MAX_BURST.
  function automatic int unsigned rx_burst_of(input int unsigned mark);
    int unsigned want;
    int unsigned b;
    want = mark + 1;
    b = 1;
    for (int k = 1; (1 << k) <= MAX_BURST; k++) begin
      if ((1 << k) <= want) b = 1 << k;
    end
    return b;
  endfunction

  // Free words in a FIFO of the given depth.
  function automatic int unsigned tx_space(input int unsigned level, input int unsigned depth);
    return (level >= depth) ? 0 : depth - level;
  endfunction

  // Transmit burst length: a quarter of the depth, at least one word.
  function automatic int unsigned tx_burst_of(input int unsigned depth);
    return (depth / 4 == 0) ? 1 : depth / 4;
  endfunction

endpackage

// File: rtl/spi_dreq_hs.sv
module spi_dreq_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic use_burst,
  input  logic ack,
  output logic single_q,
  output logic burst_q,
  output logic hold_q
);

  logic fire;

  assign fire = want & ~ack & ~hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      burst_q  <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      hold_q   <= ack;
      single_q <= fire & ~use_burst;
      burst_q  <= fire & use_burst;
    end
  end

endmodule

// File: rtl/spi_dreq_tx_chan.sv
module spi_dreq_tx_chan
  import spi_dreq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] mark,
  input  logic             ack,
  output logic             single_q,
  output logic             burst_q,
  output logic             want,
  output logic             hold_q
);

  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(tx_burst_of(DEPTH));

  logic [LVL_W-1:0] space;
  logic             use_burst;

  assign space     = LVL_W'(tx_space(32'(level), DEPTH));
  assign want      = enable && (level <= mark) && (space != '0);
  assign use_burst = (space >= BURST_L);

  spi_dreq_hs i_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .use_burst (use_burst),
    .ack       (ack),
    .single_q  (single_q),
    .burst_q   (burst_q),
    .hold_q    (hold_q)
  );

endmodule

// File: rtl/spi_dreq_rx_chan.sv
module spi_dreq_rx_chan
  import spi_dreq_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [LVL_W-1:0]     level,
  input  logic [RX_MARK_W-1:0] mark,
  input  logic                 ack,
  output logic                 single_q,
  output logic                 burst_q,
  output logic                 want,
  output logic                 hold_q
);

  logic [LVL_W-1:0] eff_burst;
  logic             use_burst;

  assign eff_burst = LVL_W'(rx_burst_of(32'(mark)));
  assign want      = enable && (level >= eff_burst);
  assign use_burst = (eff_burst != LVL_W'(1));

  spi_dreq_hs i_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .use_burst (use_burst),
    .ack       (ack),
    .single_q  (single_q),
    .burst_q   (burst_q),
    .hold_q    (hold_q)
  );

endmodule

// File: rtl/spi_dma_req_gen.sv
module spi_dma_req_gen
  import spi_dreq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_en,
  input  logic [1:0]           dma_ctl,
  input  logic [LVL_W-1:0]     tx_level,
  input  logic [LVL_W-1:0]     rx_level,
  input  logic [LVL_W-1:0]     tx_mark,
  input  logic [RX_MARK_W-1:0] rx_mark,
  input  logic                 tx_ack,
  input  logic                 rx_ack,
  output logic                 tx_single_req,
  output logic                 tx_burst_req,
  output logic                 rx_single_req,
  output logic                 rx_burst_req
);

  logic tx_enable;
  logic rx_enable;
  logic tx_want;
  logic rx_want;
  logic tx_hold;
  logic rx_hold;

  assign rx_enable = ctrl_en & dma_ctl[0];
  assign tx_enable = ctrl_en & dma_ctl[1];

  spi_dreq_tx_chan #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
  ) i_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (tx_enable),
    .level    (tx_level),
    .mark     (tx_mark),
    .ack      (tx_ack),
    .single_q (tx_single_req),
    .burst_q  (tx_burst_req),
    .want     (tx_want),
    .hold_q   (tx_hold)
  );

  spi_dreq_rx_chan #(
    .LVL_W (LVL_W)
  ) i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (rx_enable),
    .level    (rx_level),
    .mark     (rx_mark),
    .ack      (rx_ack),
    .single_q (rx_single_req),
    .burst_q  (rx_burst_req),
    .want     (rx_want),
    .hold_q   (rx_hold)
  );

endmodule

// File: rtl/spi_dma_req_gen_chk.sv
module spi_dma_req_gen_chk #(
  parameter int unsigned LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic [1:0]       dma_ctl,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] tx_mark,
  input logic [2:0]       rx_mark,
  input logic             tx_ack,
  input logic             rx_ack,
  input logic             tx_single_req,
  input logic             tx_burst_req,
  input logic             rx_single_req,
  input logic             rx_burst_req
);

  logic tx_any;
  logic rx_any;

  assign tx_any = tx_single_req | tx_burst_req;
  assign rx_any = rx_single_req | rx_burst_req;

  // R3
  ctrl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !(tx_any || rx_any));

  // R2
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_ctl[1] |=> !tx_any);

  // R2
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_ctl[0] |=> !rx_any);

  // R5
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_single_req, tx_burst_req}));

  // R7
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_single_req, rx_burst_req}));

  // R4
  tx_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_any |-> ($past(tx_level) <= $past(tx_mark)));

  // R7
  rx_burst_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_burst_req |-> ($past(rx_mark) != 3'd0));

  // R8
  tx_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> !tx_any ##1 !tx_any);

  // R8
  rx_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |=> !rx_any ##1 !rx_any);

endmodule

bind spi_dma_req_gen spi_dma_req_gen_chk #(.LVL_W(LVL_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_en       (ctrl_en),
  .dma_ctl       (dma_ctl),
  .tx_level      (tx_level),
  .tx_mark       (tx_mark),
  .rx_mark       (rx_mark),
  .tx_ack        (tx_ack),
  .rx_ack        (rx_ack),
  .tx_single_req (tx_single_req),
  .tx_burst_req  (tx_burst_req),
  .rx_single_req (rx_single_req),
  .rx_burst_req  (rx_burst_req)
);

// File: tb/test_spi_dma_req_gen.sv
module test_spi_dma_req_gen;

  localparam int DEPTH = 32;
  localparam int LVL_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctrl_en = 1'b0;
  logic [1:0]       dma_ctl = 2'b00;
  logic [LVL_W-1:0] tx_level = '0;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] tx_mark = '0;
  logic [2:0]       rx_mark = '0;
  logic             tx_ack = 1'b0;
  logic             rx_ack = 1'b0;
  logic             tx_single_req;
  logic             tx_burst_req;
  logic             rx_single_req;
  logic             rx_burst_req;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic hold_t = 1'b0;
  logic hold_r = 1'b0;

  always #4 clk = ~clk;

  spi_dma_req_gen #(.DEPTH(DEPTH)) i_spi_dma_req_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_en       (ctrl_en),
    .dma_ctl       (dma_ctl),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .tx_mark       (tx_mark),
    .rx_mark       (rx_mark),
    .tx_ack        (tx_ack),
    .rx_ack        (rx_ack),
    .tx_single_req (tx_single_req),
    .tx_burst_req  (tx_burst_req),
    .rx_single_req (rx_single_req),
    .rx_burst_req  (rx_burst_req)
  );

  // Effective receive burst restated as a threshold ladder (R6).
  function automatic int eff_rx(input int m);
    if (m >= 7) return 8;
    if (m >= 3) return 4;
    if (m >= 1) return 2;
    return 1;
  endfunction

  // Expected {tx_single, tx_burst, rx_single, rx_burst} after the next edge.
  function automatic logic [3:0] model();
    int tl, free, rb;
    logic tgo, rgo;
    logic [3:0] r;
    tl   = int'(tx_level);
    free = DEPTH - tl;
    tgo  = ctrl_en && dma_ctl[1] && (tl <= int'(tx_mark)) && (free > 0) && !tx_ack && !hold_t;
    rb   = eff_rx(int'(rx_mark));
    rgo  = ctrl_en && dma_ctl[0] && (int'(rx_level) >= rb) && !rx_ack && !hold_r;
    r[3] = tgo && (free < DEPTH / 4);
    r[2] = tgo && (free >= DEPTH / 4);
    r[1] = rgo && (rb == 1);
    r[0] = rgo && (rb > 1);
    return r;
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] got;
    got = {tx_single_req, tx_burst_req, rx_single_req, rx_burst_req};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b", tag, got, exp);
    end
  endtask

  // Inputs are set at a falling edge; result checked just after the rising edge.
  task automatic step(input string tag);
    logic [3:0] e;
    e = model();
    @(posedge clk);
    #1;
    check(e, tag);
    hold_t = tx_ack;
    hold_r = rx_ack;
    cycles++;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got=hung exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5151));
    @(negedge clk);
    ctrl_en = 1'b1;
    dma_ctl = 2'b11;
    tx_mark = 6'd15;
    tx_level = 6'd0;
    rx_level = 6'd20;
    repeat (2) @(posedge clk);
    #1;
    check(4'b0000, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    ctrl_en = 1'b0;
    step("R1 first clock after reset");

    // Transmit watermark boundary (R4) and burst/single split (R5)
    ctrl_en = 1'b1;
    dma_ctl = 2'b10;
    tx_mark = 6'd15;
    tx_level = 6'd15;
    step("R4 level at mark");
    tx_level = 6'd16;
    step("R4 level above mark");
    tx_mark = 6'd32;
    tx_level = 6'd24;
    step("R5 free equals quarter");
    tx_level = 6'd25;
    step("R5 free below quarter");
    tx_level = 6'd32;
    step("R4 fifo full");

    // Receive burst rounding (R6, R7)
    dma_ctl = 2'b01;
    for (int m = 0; m < 8; m++) begin
      rx_mark = 3'(m);
      rx_level = 6'(eff_rx(m) - 1);
      step("R6 level one below burst");
      rx_level = 6'(eff_rx(m));
      step("R7 level at burst");
    end

    // Enables (R2, R3)
    dma_ctl = 2'b11;
    tx_mark = 6'd15;
    tx_level = 6'd2;
    rx_mark = 3'd3;
    rx_level = 6'd10;
    step("R2 both enabled");
    dma_ctl = 2'b01;
    step("R2 tx disabled");
    dma_ctl = 2'b10;
    step("R2 rx disabled");
    dma_ctl = 2'b11;
    ctrl_en = 1'b0;
    step("R3 controller off");
    ctrl_en = 1'b1;
    step("R3 controller back on");

    // Acknowledge quiet window (R8)
    tx_ack = 1'b1;
    step("R8 tx ack cycle");
    tx_ack = 1'b0;
    step("R8 tx hold cycle");
    step("R8 tx re-evaluated");
    rx_ack = 1'b1;
    step("R8 rx ack cycle");
    rx_ack = 1'b0;
    step("R8 rx hold cycle");
    step("R8 rx re-evaluated");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      ctrl_en  = ($urandom % 10) != 0;
      dma_ctl  = 2'($urandom);
      tx_level = 6'($urandom % (DEPTH + 1));
      rx_level = 6'($urandom % (DEPTH + 1));
      tx_mark  = 6'($urandom % (DEPTH + 1));
      rx_mark  = 3'($urandom);
      tx_ack   = ($urandom % 4) == 0;
      rx_ack   = ($urandom % 4) == 0;
      step("R4 R5 R7 R8 random");
    end

    finish_run();
  end

endmodule